// File: doc/BRIEF.md
# Round-Robin Single-Byte Request Sequencer

This block drives a series of one-byte memory requests across a group of requester ports, serving them one at a time in ascending port order. Only one request is in flight at any moment: the block offers a request to the selected port, waits for that port to take it, and then waits for a completion that names the same port and address. After the last port has been served at an address, the address moves forward by a fixed step and the sweep starts again at port 0.

Each request is either a read or a write. The choice is made by comparing a pseudo-random number in the range 0 to 100 with a write-percentage input. A counter reports how many full sweeps have finished. A completion that does not match the request in flight raises a sticky error flag and is otherwise ignored. This makes the block a simple traffic source for exercising a shared memory system from several ports.

Top module: `rr_req_sequencer`

## Requirements
- R1: On reset the block is idle, at port 0 and address 0. `sweep_count` and `err` are 0, and no `req_valid` bit is set.
- R2: At most one `req_valid` bit is set at a time. The set bit is always that of the current port, and no bit is set while a request is outstanding.
- R3: Once a `req_valid` bit is set, it stays set with `req_addr` and `req_write` unchanged until the same port's `req_ready` is sampled high.
- R4: In the cycle after a port accepts a request, `req_valid` is all zero. It stays zero until a matching completion arrives.
- R5: The random source is a 16-bit right-shifting Galois LFSR. It starts at SEED, and each clock it becomes (v>>1) XOR (v[0] ? 0xB400 : 0). After reset, the block spends one idle cycle drawing before `req_valid` rises. In that cycle it takes r = v mod 101 from the current LFSR value. The request is a write (`req_write`=1) when r < `wr_pct`, and a read otherwise.
- R6: `wr_pct` is sampled only in the draw cycle. A change to it does not alter a request that is already being offered.
- R7: A matching completion makes the block idle again and moves it to the next port. The next request's draw happens in the cycle after the completion.
- R8: A completion from the last port (NPORTS-1) makes the next port 0. It also adds STEP to the address, modulo 2^AW, and increments `sweep_count` by one.
- R9: A completion is matching only when it arrives while a request is outstanding, names the current port on `cpl_port` and carries the current address on `cpl_addr`. Any other completion sets `err`, which stays set until reset, and leaves port, address, state and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_pct | input | 7 | Write percentage (0 gives all reads, values above 100 give all writes) |
| req_valid | output | NPORTS | Per-port request valid |
| req_ready | input | NPORTS | Per-port request ready |
| req_addr | output | AW | Byte address of the offered request |
| req_write | output | 1 | 1 = write, 0 = read |
| cpl_valid | input | 1 | Completion strobe |
| cpl_port | input | PW | Port index named by the completion |
| cpl_addr | input | AW | Address named by the completion |
| sweep_count | output | CW | Number of full sweeps completed |
| err | output | 1 | Sticky flag for an unexpected completion |

## Verification
The hardest situations to reach are bad completions that arrive at precise moments. A matching completion shows up only after an acceptance, so the bench places bad completions at exact points. It sends a completion while the block is idle. It sends one with the wrong port, and one with the right port but a flipped address bit, both while the real request is still waiting for its delayed completion. Each case follows its own reset, so the sticky flag and the ignored state can be seen separately. Random per-port ready stalls and completion delays of 0 to 3 cycles stretch the hold phase. Write percentages of 50, 0 and the boundary value 100 exercise the read/write choice.

// File: rtl/rr_req_sequencer.sv
module rr_req_sequencer #(
  parameter int          NPORTS = 4,
  parameter int          AW     = 16,
  parameter int          STEP   = 4,
  parameter int          CW     = 16,
  parameter logic [15:0] SEED   = 16'hACE1,
  parameter int          PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        wr_pct,
  output logic [NPORTS-1:0] req_valid,
  input  logic [NPORTS-1:0] req_ready,
  output logic [AW-1:0]     req_addr,
  output logic              req_write,
  input  logic              cpl_valid,
  input  logic [PW-1:0]     cpl_port,
  input  logic [AW-1:0]     cpl_addr,
  output logic [CW-1:0]     sweep_count,
  output logic              err
);
  typedef enum logic {ST_IDLE = 1'b0, ST_PEND = 1'b1} st_t;

  st_t         state;
  logic        offered;
  logic        wr_q;
  logic [PW-1:0] idx;
  logic [AW-1:0] addr;
  logic [15:0] lfsr;
  logic [6:0]  rnd;
  logic        cpl_ok;
  logic        last_port;
  logic        offering;

  assign rnd       = 7'(lfsr % 16'd101);
  assign last_port = (idx == PW'(NPORTS - 1));
  assign cpl_ok    = cpl_valid && (state == ST_PEND) && (cpl_port == idx) && (cpl_addr == addr);
  assign offering  = (state == ST_IDLE) && offered;
  assign req_addr  = addr;
  assign req_write = wr_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_valid
    assign req_valid[p] = offering && (idx == PW'(p));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      offered     <= 1'b0;
      wr_q        <= 1'b0;
      idx         <= '0;
      addr        <= '0;
      sweep_count <= '0;
      err         <= 1'b0;
    end else begin
      if (state == ST_IDLE) begin
        if (!offered) begin
          offered <= 1'b1;
          wr_q    <= (rnd < wr_pct);
        end else if (req_ready[idx]) begin
          state   <= ST_PEND;
          offered <= 1'b0;
        end
      end
      if (cpl_valid) begin
        if (cpl_ok) begin
          state <= ST_IDLE;
          if (last_port) begin
            idx         <= '0;
            addr        <= addr + AW'(STEP);
            sweep_count <= sweep_count + 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          err <= 1'b1;
        end
      end
    end
  end
endmodule

module rr_req_sequencer_chk #(
  parameter int NPORTS = 4,
  parameter int AW     = 16,
  parameter int CW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] req_valid,
  input logic [NPORTS-1:0] req_ready,
  input logic [AW-1:0]     req_addr,
  input logic              req_write,
  input logic [CW-1:0]     sweep_count,
  input logic              err
);
  // R2
  one_offer_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_valid));
  // R3
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid && !(|(req_valid & req_ready))) |=>
      ($stable(req_valid) && $stable(req_addr) && $stable(req_write)));
  // R4
  quiet_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> (req_valid == '0));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sweep_count) |-> (sweep_count == $past(sweep_count) + 1'b1));
  // R8
  addr_with_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(req_addr) |-> !$stable(sweep_count));
endmodule

bind rr_req_sequencer rr_req_sequencer_chk #(.NPORTS(NPORTS), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .sweep_count(sweep_count), .err(err)
);

// File: tb/rr_req_sequencer_bench.sv
module rr_req_sequencer_bench;
  localparam int NPORTS = 4;
  localparam int AW     = 16;
  localparam int STEP   = 4;
  localparam int CW     = 16;
  localparam int PW     = 2;
  localparam logic [15:0] SEED = 16'hACE1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [6:0]        wr_pct = 7'd50;
  logic [NPORTS-1:0] req_valid;
  logic [NPORTS-1:0] req_ready = '0;
  logic [AW-1:0]     req_addr;
  logic              req_write;
  logic              cpl_valid = 1'b0;
  logic [PW-1:0]     cpl_port = '0;
  logic [AW-1:0]     cpl_addr = '0;
  logic [CW-1:0]     sweep_count;
  logic              err;

  always #5 clk = ~clk;

  rr_req_sequencer #(.NPORTS(NPORTS), .AW(AW), .STEP(STEP), .CW(CW), .SEED(SEED)) u_rr_req_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_pct(wr_pct), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .cpl_valid(cpl_valid), .cpl_port(cpl_port),
    .cpl_addr(cpl_addr), .sweep_count(sweep_count), .err(err)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int  m_pend, m_off, m_wr, m_idx, m_addr, m_cnt, m_err, m_lfsr;
  int  acc_seq = 0, acc_port, acc_addr;
  int  draws = 0, wdraws = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_off = 0; m_wr = 0; m_idx = 0; m_addr = 0; m_cnt = 0; m_err = 0;
      m_lfsr = SEED;
    end else begin
      int nl;
      bit good;
      nl = (m_lfsr >> 1) ^ ((m_lfsr & 1) ? 'hB400 : 0);
      good = cpl_valid && m_pend && (int'(cpl_port) == m_idx) && (int'(cpl_addr) == m_addr);
      if (!m_pend) begin
        if (!m_off) begin
          m_off = 1;
          m_wr = ((m_lfsr % 101) < int'(wr_pct)) ? 1 : 0;
          draws++; wdraws += m_wr;
        end else if (req_ready[m_idx]) begin
          m_pend = 1; m_off = 0;
          acc_port = m_idx; acc_addr = m_addr; acc_seq++;
        end
      end
      if (cpl_valid) begin
        if (good) begin
          m_pend = 0;
          m_idx++;
          if (m_idx == NPORTS) begin
            m_idx = 0;
            m_addr = (m_addr + STEP) % (1 << AW);
            m_cnt = (m_cnt + 1) % (1 << CW);
          end
        end else m_err = 1;
      end
      m_lfsr = nl;
    end
  end

  // compare and drive on the falling edge
  int  seen_seq = 0;
  bit  rp = 0;
  int  rport, raddr, rdly;
  int  inj = 0;
  int  rdy_all = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NPORTS-1:0] ev;
      ev = (!m_pend && m_off) ? (NPORTS'(1) << m_idx) : '0;
      chk(req_valid == ev, "R2/R4 req_valid", req_valid, ev);
      if (m_off && !m_pend) begin
        chk(int'(req_addr) == m_addr, "R3/R8 req_addr", req_addr, m_addr);
        chk(int'(req_write) == m_wr, "R5/R6 req_write", req_write, m_wr);
      end
      chk(int'(sweep_count) == m_cnt, "R7/R8 sweep_count", sweep_count, m_cnt);
      chk(int'(err) == m_err, "R9 err", err, m_err);
    end
    cpl_valid = 1'b0;
    if (!rst_n) begin rp = 0; seen_seq = acc_seq; end
    else begin
      if (acc_seq != seen_seq) begin
        seen_seq = acc_seq; rp = 1; rport = acc_port; raddr = acc_addr; rdly = $urandom % 4;
      end
      if (rp && rdly == 0 && inj == 0) begin
        cpl_valid = 1'b1; cpl_port = PW'(rport); cpl_addr = AW'(raddr); rp = 0;
      end else if (inj == 1 && !rp && !m_pend) begin
        cpl_valid = 1'b1; cpl_port = '0; cpl_addr = '0; inj = 0;
      end else if (inj == 2 && rp) begin
        cpl_valid = 1'b1; cpl_port = PW'((rport + 1) % NPORTS); cpl_addr = AW'(raddr); inj = 0;
      end else if (inj == 3 && rp) begin
        cpl_valid = 1'b1; cpl_port = PW'(rport); cpl_addr = AW'(raddr ^ 1); inj = 0;
      end else if (rp && rdly > 0) rdly--;
    end
    for (int p = 0; p < NPORTS; p++) req_ready[p] = rdy_all ? 1'b1 : (($urandom % 3) != 0);
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(req_valid == '0, "R1 req_valid in reset", req_valid, 0);
    chk(sweep_count == '0, "R1 sweep_count in reset", sweep_count, 0);
    chk(err == 1'b0, "R1 err in reset", err, 0);
    rst_n = 1'b1;
    #1;
    // R1
    chk(req_valid == '0, "R1 no offer before draw", req_valid, 0);
    chk(req_addr == '0, "R1 address zero", req_addr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c0;
    do_reset();
    wr_pct = 7'd50;
    repeat (800) @(negedge clk);
    // R8
    chk(sweep_count > 0, "R8 sweeps progressed", sweep_count, 1);
    wr_pct = 7'd0; draws = 0; wdraws = 0;
    repeat (400) @(negedge clk);
    // R5
    chk(wdraws == 0, "R5 pct 0 gives reads", wdraws, 0);
    wr_pct = 7'd100; rdy_all = 1;
    repeat (400) @(negedge clk);
    // R6 toggle pct mid-offer; model decides at draw only
    rdy_all = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); wr_pct = 7'($urandom % 128); end
    c0 = int'(sweep_count);
    // R9 completion while idle
    wr_pct = 7'd50;
    wait (!m_pend && !rp); inj = 1;
    repeat (6) @(negedge clk);
    chk(err == 1'b1, "R9 idle completion flags err", err, 1);
    chk(int'(sweep_count) >= c0, "R9 count not disturbed", sweep_count, c0);
    do_reset();
    repeat (20) @(negedge clk);
    // R9 wrong port
    wait (rp && rdly > 0); inj = 2;
    repeat (30) @(negedge clk);
    chk(err == 1'b1, "R9 wrong port flags err", err, 1);
    do_reset();
    repeat (20) @(negedge clk);
    // R9 wrong address
    wait (rp && rdly > 0); inj = 3;
    repeat (30) @(negedge clk);
    chk(err == 1'b1, "R9 wrong address flags err", err, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule